// File: doc/BRIEF.md
# Sequential Frame-Buffer Fetch and Pixel Shifter

This block turns a byte-packed monochrome frame buffer into a serial pixel stream. A single address counter walks the buffer upward from a fixed base address. Each byte carries eight consecutive pixels. The block asks a shared-memory arbiter for one byte per eight pixel clocks. It parks the returned byte in a staging register, then moves it into a shift register and sends it out one bit per pixel clock. The stream therefore has no gaps, provided the arbiter grants each request within a few clocks.

A timing generator supplies two inputs. The first is a frame-start strobe, which rewinds the counter and immediately requests the first byte during blanking. The second is a visible-area level, which clocks out pixels. Fetch timing depends only on these pixel-clock events. It is independent of whatever clock the other bus master runs on. Read data is expected to be valid in the same cycle in which the grant is given.

Top module: `vid_byte_fetch`

## Requirements
- R1: While reset is held, and after it until the first frame start, `fetch_req` is 0, `pixel` is 0 and `rd_addr` equals the base address (0x2400 by default).
- R2: One clock edge after a cycle with `frame_start` high, `rd_addr` equals the base address and `fetch_req` is 1. Any grant in that same cycle is discarded.
- R3: A grant is a cycle with `fetch_req` and `grant` both high. `rd_data` is captured in that cycle. After the next edge, `fetch_req` is 0 and `rd_addr` has advanced by exactly one, unless the byte just fetched was the last byte of the frame.
- R4: Once raised, `fetch_req` stays high on every following cycle until a grant occurs.
- R5: While `visible` is high, `pixel` carries the bytes in ascending address order, starting with the byte at the base address. Each byte occupies eight consecutive visible cycles, bit 0 first and bit 7 last, with no gap between bytes. Visible runs are whole multiples of eight cycles.
- R6: `pixel` is 0 in every cycle where `visible` is low.
- R7: `fetch_req` rises only on the edge after a `frame_start` cycle, or on the edge after the first visible cycle of a byte. No request is raised, and the address does not move, because of blanking.
- R8: After NUM_BYTES grants in a frame, `fetch_req` stays 0 and `rd_addr` stays at base + NUM_BYTES − 1. Any further visible cycles give `pixel` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle strobe that rewinds the buffer walk |
| visible | input | 1 | High on each pixel clock inside the displayed area |
| grant | input | 1 | Arbiter grant for the pending byte read |
| rd_data | input | 8 | Frame-buffer byte, valid in the grant cycle |
| rd_addr | output | ADDR_W | Frame-buffer address of the byte being requested |
| fetch_req | output | 1 | Byte read request, held until granted |
| pixel | output | 1 | Serial monochrome pixel |

## Verification
`pixel` is combinational from `visible` and registered state. It is therefore due in the same cycle as the visible strobe that selects it. `rd_addr` and `fetch_req` answer a grant or a frame start one clock edge later. The bench drives inputs on the falling edge and samples two nanoseconds later, before the next rising edge. Every comparison thus sees the state from the edge just passed together with the inputs of the current cycle. Grant latency is varied between zero and four cycles. Expected pixels come from a count of visible cycles and an arithmetic memory pattern.

// File: rtl/vid_byte_fetch.sv
module vid_byte_fetch #(
  parameter int ADDR_W = 16,
  parameter logic [15:0] BASE_ADDR = 16'h2400,
  parameter int NUM_BYTES = 7168
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              visible,
  input  logic              grant,
  input  logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              fetch_req,
  output logic              pixel
);
  localparam int BYTE_W = 8;
  localparam int PH_W   = $clog2(BYTE_W);
  localparam int CNT_W  = $clog2(NUM_BYTES + 1);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] LAST = BASE + ADDR_W'(NUM_BYTES - 1);

  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  left_q;
  logic [BYTE_W-1:0] stage_q, shift_q;
  logic              full_q, req_q;
  logic [PH_W-1:0]   phase_q;

  wire take = visible && (phase_q == '0);
  wire hit  = req_q && grant;
  wire [BYTE_W-1:0] cur = take ? (full_q ? stage_q : '0) : shift_q;

  assign pixel     = visible && cur[0];
  assign rd_addr   = addr_q;
  assign fetch_req = req_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= BASE;
      left_q  <= '0;
      stage_q <= '0;
      shift_q <= '0;
      full_q  <= 1'b0;
      req_q   <= 1'b0;
      phase_q <= '0;
    end else if (frame_start) begin
      addr_q  <= BASE;
      left_q  <= CNT_W'(NUM_BYTES);
      shift_q <= '0;
      full_q  <= 1'b0;
      req_q   <= 1'b1;
      phase_q <= '0;
    end else begin
      if (visible) begin
        phase_q <= phase_q + PH_W'(1);
        shift_q <= cur >> 1;
      end
      if (take) begin
        full_q <= 1'b0;
        if (left_q != '0) req_q <= 1'b1;
      end
      if (hit) begin
        stage_q <= rd_data;
        full_q  <= 1'b1;
        req_q   <= 1'b0;
        left_q  <= left_q - CNT_W'(1);
        if (left_q > CNT_W'(1)) addr_q <= addr_q + ADDR_W'(1);
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req && !grant |=> fetch_req); // R4
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req && grant && !frame_start && (rd_addr != LAST) |=>
      (rd_addr == $past(rd_addr) + ADDR_W'(1)) && !fetch_req); // R3
  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr >= BASE) && (rd_addr <= LAST)); // R8
  AST_FRAME_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (rd_addr == BASE) && fetch_req); // R2
  AST_NO_REQ_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    !visible && !frame_start && !fetch_req |=> !fetch_req); // R7
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (left_q == '0) |-> !fetch_req); // R8
endmodule

// File: tb/tb_vid_byte_fetch.sv
module tb_vid_byte_fetch;
  localparam int NB = 40;
  localparam int WB = 4;
  localparam logic [15:0] BASE = 16'h2400;

  logic clk = 0, rst_n = 0, frame_start = 0, visible = 0, grant = 0;
  logic [7:0] rd_data;
  logic [15:0] rd_addr;
  logic fetch_req, pixel;

  int nchk = 0, nfail = 0;
  int vcount = 0, gcount = 0, wcnt = 0, dly = 0, dstep = 1;
  bit p_req = 0, p_grant = 0, p_fs = 0, p_take = 0;

  always #4 clk = ~clk;

  function automatic logic [7:0] pat(input logic [15:0] a);
    return (a[7:0] * 8'd29) ^ a[15:8] ^ 8'h5A;
  endfunction

  assign rd_data = pat(rd_addr);

  vid_byte_fetch #(.ADDR_W(16), .BASE_ADDR(BASE), .NUM_BYTES(NB)) dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .visible(visible),
    .grant(grant), .rd_data(rd_data), .rd_addr(rd_addr),
    .fetch_req(fetch_req), .pixel(pixel));

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", r, act, exp, $time);
    end
  endtask

  task automatic step(input bit vis, input bit fs);
    logic [7:0] b;
    bit exp_pix;
    int bi;
    @(negedge clk);
    visible = vis;
    frame_start = fs;
    grant = !fs && fetch_req && (wcnt >= dly);
    #2;
    bi = vcount / 8;
    b = pat(BASE + 16'(bi));
    exp_pix = vis && (bi < NB) && b[vcount % 8];
    if (vis) chk(pixel == exp_pix, "R5", int'(pixel), int'(exp_pix));
    else     chk(pixel == 1'b0, "R6", int'(pixel), 0);
    if (p_fs) begin
      chk(rd_addr == BASE, "R2", int'(rd_addr), int'(BASE));
      chk(fetch_req == 1'b1, "R2", int'(fetch_req), 1);
    end else begin
      if (p_req && !p_grant) chk(fetch_req == 1'b1, "R4", int'(fetch_req), 1);
      if (p_grant) chk(fetch_req == 1'b0, "R3", int'(fetch_req), 0);
      if (fetch_req && !p_req) chk(p_take, "R7", int'(p_take), 1);
    end
    if (grant) chk(rd_addr == BASE + 16'(gcount), "R3", int'(rd_addr), int'(BASE) + gcount);
    if (gcount == NB && !p_fs) begin
      chk(fetch_req == 1'b0, "R8", int'(fetch_req), 0);
      chk(rd_addr == BASE + 16'(NB - 1), "R8", int'(rd_addr), int'(BASE) + NB - 1);
    end
    p_take = vis && (vcount % 8 == 0) && (gcount < NB);
    if (grant) begin
      gcount++;
      dly = (dly + dstep) % 5;
    end
    wcnt = (fetch_req && !grant) ? wcnt + 1 : 0;
    if (fs) begin vcount = 0; gcount = 0; wcnt = 0; end
    else if (vis) vcount++;
    p_req = fetch_req; p_grant = grant; p_fs = fs;
  endtask

  task automatic line(input int blank);
    for (int i = 0; i < WB * 8; i++) step(1, 0);
    for (int i = 0; i < blank; i++) step(0, 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    nchk++; nfail++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk(fetch_req == 1'b0, "R1", int'(fetch_req), 0);
    chk(pixel == 1'b0, "R1", int'(pixel), 0);
    chk(rd_addr == BASE, "R1", int'(rd_addr), int'(BASE));
    @(negedge clk); rst_n = 1;
    for (int i = 0; i < 4; i++) begin
      step(0, 0);
      chk(fetch_req == 1'b0 && rd_addr == BASE, "R1", int'(rd_addr), int'(BASE));
    end
    step(0, 1);
    for (int i = 0; i < 9; i++) step(0, 0);
    for (int l = 0; l < NB / WB; l++) line(12);
    line(12);
    for (int i = 0; i < 6; i++) step(0, 0);
    dstep = 2;
    step(0, 1);
    for (int i = 0; i < 7; i++) step(0, 0);
    line(10); line(10);
    step(0, 1);
    for (int i = 0; i < 8; i++) step(0, 0);
    dstep = 3;
    for (int l = 0; l < NB / WB; l++) line(9);
    line(9);
    summary();
  end
endmodule